// File: doc/BRIEF.md
# Secure-Filtered Interrupt State Bitmaps

This block stores, for every shared peripheral interrupt, three state bits: enabled, pending and active. Software reaches each bitmap through a 32-bit set window and a 32-bit clear window on a single-cycle register bus. Every access carries a secure attribute. A per-interrupt group bitmap and a graded 2-bit non-secure permission field decide which bits a non-secure access may see or change.

The block also watches one input line per shared interrupt. A rising edge on a line configured as edge-triggered latches the pending bit. For a level-triggered interrupt, a pending read returns the latched bit ORed with the live line level. A chip-level input, `sec_off`, disables the security model, after which every access has full rights.

Top module: `secure_irq_bitmaps`

## Requirements
- R1: Bitmap word n covers interrupt IDs 32n to 32n+31. Word 0 holds the internal IDs below 32, and words at index NUM_IRQ/32 or above are unimplemented. Both read as zero and ignore writes.
- R2: The window code is addr[7:5]: 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 permission fields. The word index is addr[4:0]. Permission word k covers IDs 16k to 16k+15, and the field of ID i sits at bits [2(i%16)+1 : 2(i%16)]. Permission words for IDs below 32 or at or above NUM_IRQ read as zero and ignore writes.
- R3: In a set window, a written 1 sets the bit and a written 0 leaves it unchanged. In a clear window, a written 1 clears the bit and a written 0 leaves it unchanged. A read of either window returns the current bitmap.
- R4: A write takes effect on the clock edge that accepts it. rd_data carries the value in the cycle after rd_en is high, and is zero in the cycle after a cycle with rd_en low.
- R5: When security is enabled, a non-secure access to an enable window sees and changes only the bits whose group bit is 1. All other bits read as zero.
- R6: For a non-secure access with security enabled, the pending-set window permits bits whose group bit is 1 or whose field is at least 1. The pending-clear window permits bits whose group bit is 1 or whose field is at least 2. The same mask applies to reads and writes.
- R7: For a non-secure access with security enabled, a read of either active window permits bits whose group bit is 1 or whose field is at least 2. Writes to the active windows permit only bits whose group bit is 1.
- R8: The group window can be read and written only by a secure access, or by any access while sec_off is 1. Any other access reads zero and its write is ignored.
- R9: The permission window can be read and written only by a secure access while sec_off is 0. Any other access reads zero and its write is ignored.
- R10: For an interrupt whose edge_cfg bit is 0, a pending read returns the latched bit ORed with the current line level.
- R11: A 0-to-1 transition on a line sets the latched pending bit only when that interrupt's edge_cfg bit is 1. A falling edge or a steady level does not change the latched bit.
- R12: When a rising edge and a pending-clear write for the same interrupt arrive in the same cycle, the pending bit ends up set.
- R13: While sec_off is 1, non-secure accesses have the same rights as secure accesses to the group, enable, pending and active windows.
- R14: After reset, every bitmap, every permission field and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_off | input | 1 | 1 disables the security model |
| edge_cfg | input | NUM_IRQ-32 | Bit j set: ID 32+j is edge-triggered |
| irq_line | input | NUM_IRQ-32 | Bit j: input line of ID 32+j |
| addr | input | ADDR_W | Window code and word index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| secure | input | 1 | 1 for a secure access |
| rd_data | output | 32 | Read data, registered |

## Verification
The assertions assume that the bus never raises wr_en and rd_en in the same cycle. They also assume that edge_cfg changes only while the corresponding line is steady, so that a rise is caused by the line alone. The bench drives every input on the falling clock edge and issues exactly one bus operation per transaction. It changes edge_cfg only while all lines are low, and raises a line in the same cycle as a clear write only in the one test aimed at R12.

// File: rtl/irqbm_pkg.sv
package irqbm_pkg;
    parameter int WB = 32;

    typedef enum logic [2:0] {
        WIN_GROUP  = 3'd0,
        WIN_EN_SET = 3'd1,
        WIN_EN_CLR = 3'd2,
        WIN_PD_SET = 3'd3,
        WIN_PD_CLR = 3'd4,
        WIN_AC_SET = 3'd5,
        WIN_AC_CLR = 3'd6,
        WIN_ACCESS = 3'd7
    } win_e;

    // One bit per interrupt: its 2-bit field is nonzero
    function automatic logic [WB-1:0] field_ge1(input logic [2*WB-1:0] f);
        logic [WB-1:0] r;
        for (int i = 0; i < WB; i++) r[i] = f[2*i] | f[2*i+1];
        return r;
    endfunction

    // One bit per interrupt: its 2-bit field is 2 or 3
    function automatic logic [WB-1:0] field_ge2(input logic [2*WB-1:0] f);
        logic [WB-1:0] r;
        for (int i = 0; i < WB; i++) r[i] = f[2*i+1];
        return r;
    endfunction
endpackage

// File: rtl/irqbm_decode.sv
module irqbm_decode
    import irqbm_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx,
    output logic              map_ok,
    output logic              acc_ok
);
    localparam int WORDS = NUM_IRQ / WB;

    assign win    = win_e'(addr[ADDR_W-1 -: 3]);
    assign idx    = addr[IDX_W-1:0];
    assign map_ok = (int'(idx) >= 1) && (int'(idx) < WORDS);
    assign acc_ok = (int'(idx) >= 2) && (int'(idx) < 2 * WORDS);
endmodule

// File: rtl/irqbm_perm.sv
module irqbm_perm
    import irqbm_pkg::*;
(
    input  logic              ns,
    input  logic [WB-1:0]     grp,
    input  logic [2*WB-1:0]   fields,
    output logic [WB-1:0]     m_grp,
    output logic [WB-1:0]     m_ge1,
    output logic [WB-1:0]     m_ge2
);
    assign m_grp = ns ? grp : '1;
    assign m_ge1 = ns ? (grp | field_ge1(fields)) : '1;
    assign m_ge2 = ns ? (grp | field_ge2(fields)) : '1;
endmodule

// File: rtl/irqbm_word.sv
module irqbm_word
    import irqbm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            grp_ok,
    input  logic            acc_lo_we,
    input  logic            acc_hi_we,
    input  win_e            win,
    input  logic [WB-1:0]   wdata,
    input  logic [WB-1:0]   m_grp,
    input  logic [WB-1:0]   m_ge1,
    input  logic [WB-1:0]   m_ge2,
    input  logic [WB-1:0]   line,
    input  logic [WB-1:0]   edge_cfg,
    output logic [WB-1:0]   grp_q,
    output logic [WB-1:0]   en_q,
    output logic [WB-1:0]   pd_q,
    output logic [WB-1:0]   ac_q,
    output logic [2*WB-1:0] acc_q
);
    logic [WB-1:0]   line_q, rise;
    logic [WB-1:0]   grp_n, en_n, pd_n, ac_n;
    logic [2*WB-1:0] acc_n;

    assign rise = line & ~line_q & edge_cfg;

    always_comb begin
        grp_n = grp_q;
        en_n  = en_q;
        pd_n  = pd_q;
        ac_n  = ac_q;
        acc_n = acc_q;
        if (hit) begin
            unique case (win)
                WIN_GROUP:  if (grp_ok) grp_n = wdata;
                WIN_EN_SET: en_n = en_q | (wdata & m_grp);
                WIN_EN_CLR: en_n = en_q & ~(wdata & m_grp);
                WIN_PD_SET: pd_n = pd_q | (wdata & m_ge1);
                WIN_PD_CLR: pd_n = pd_q & ~(wdata & m_ge2);
                WIN_AC_SET: ac_n = ac_q | (wdata & m_grp);
                WIN_AC_CLR: ac_n = ac_q & ~(wdata & m_grp);
                WIN_ACCESS: ;
            endcase
        end
        if (acc_lo_we) acc_n[WB-1:0]    = wdata;
        if (acc_hi_we) acc_n[2*WB-1:WB] = wdata;
        pd_n = pd_n | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            en_q   <= '0;
            pd_q   <= '0;
            ac_q   <= '0;
            acc_q  <= '0;
            line_q <= '0;
        end else begin
            grp_q  <= grp_n;
            en_q   <= en_n;
            pd_q   <= pd_n;
            ac_q   <= ac_n;
            acc_q  <= acc_n;
            line_q <= line;
        end
    end

    assert_en_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~$past(en_q) & ~$past(m_grp)) == '0));

    assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win == WIN_EN_CLR) |=> ((en_q & $past(wdata & m_grp)) == '0));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pd_q & $past(rise)) == $past(rise)));

    assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hit && (win == WIN_PD_SET || win == WIN_PD_CLR)) && rise == '0)
        |=> $stable(pd_q));
endmodule

// File: rtl/secure_irq_bitmaps.sv
module secure_irq_bitmaps
    import irqbm_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_off,
    input  logic [NUM_IRQ-33:0]  edge_cfg,
    input  logic [NUM_IRQ-33:0]  irq_line,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [WB-1:0]        wr_data,
    input  logic                 rd_en,
    input  logic                 secure,
    output logic [WB-1:0]        rd_data
);
    localparam int WORDS = NUM_IRQ / WB;

    win_e             win;
    logic [IDX_W-1:0] idx;
    logic             map_ok, acc_ok, addr_ok, ns;
    logic [WB-1:0]    grp_w [1:WORDS-1];
    logic [WB-1:0]    en_w  [1:WORDS-1];
    logic [WB-1:0]    pd_w  [1:WORDS-1];
    logic [WB-1:0]    ac_w  [1:WORDS-1];
    logic [2*WB-1:0]  acc_w [1:WORDS-1];
    logic [WB-1:0]    mg_w  [1:WORDS-1];
    logic [WB-1:0]    m1_w  [1:WORDS-1];
    logic [WB-1:0]    m2_w  [1:WORDS-1];
    logic [WB-1:0]    rd_val;

    assign ns      = !secure && !sec_off;
    assign addr_ok = (win == WIN_ACCESS) ? acc_ok : map_ok;

    irqbm_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_decode (
        .addr(addr), .win(win), .idx(idx), .map_ok(map_ok), .acc_ok(acc_ok)
    );

    for (genvar w = 1; w < WORDS; w++) begin : g_word
        logic hit, acc_lo_we, acc_hi_we;
        assign hit       = wr_en && map_ok && (win != WIN_ACCESS) && (int'(idx) == w);
        assign acc_lo_we = wr_en && acc_ok && (win == WIN_ACCESS) && secure && !sec_off
                           && (int'(idx) == 2 * w);
        assign acc_hi_we = wr_en && acc_ok && (win == WIN_ACCESS) && secure && !sec_off
                           && (int'(idx) == 2 * w + 1);

        irqbm_perm i_perm (
            .ns(ns), .grp(grp_w[w]), .fields(acc_w[w]),
            .m_grp(mg_w[w]), .m_ge1(m1_w[w]), .m_ge2(m2_w[w])
        );

        irqbm_word i_word (
            .clk(clk), .rst_n(rst_n), .hit(hit), .grp_ok(secure || sec_off),
            .acc_lo_we(acc_lo_we), .acc_hi_we(acc_hi_we), .win(win), .wdata(wr_data),
            .m_grp(mg_w[w]), .m_ge1(m1_w[w]), .m_ge2(m2_w[w]),
            .line(irq_line[WB*(w-1) +: WB]), .edge_cfg(edge_cfg[WB*(w-1) +: WB]),
            .grp_q(grp_w[w]), .en_q(en_w[w]), .pd_q(pd_w[w]), .ac_q(ac_w[w]),
            .acc_q(acc_w[w])
        );
    end

    always_comb begin
        logic [WB-1:0] s_grp, s_en, s_pd, s_ac, s_acc, s_lvl, s_mg, s_m1, s_m2;
        s_grp = '0; s_en = '0; s_pd = '0; s_ac = '0; s_acc = '0;
        s_lvl = '0; s_mg = '0; s_m1 = '0; s_m2 = '0;
        for (int w = 1; w < WORDS; w++) begin
            if (int'(idx) == w) begin
                s_grp = grp_w[w];
                s_en  = en_w[w];
                s_pd  = pd_w[w];
                s_ac  = ac_w[w];
                s_lvl = irq_line[WB*(w-1) +: WB] & ~edge_cfg[WB*(w-1) +: WB];
                s_mg  = mg_w[w];
                s_m1  = m1_w[w];
                s_m2  = m2_w[w];
            end
            if (int'(idx >> 1) == w)
                s_acc = idx[0] ? acc_w[w][2*WB-1:WB] : acc_w[w][WB-1:0];
        end
        unique case (win)
            WIN_GROUP:                rd_val = (secure || sec_off) ? s_grp : '0;
            WIN_EN_SET, WIN_EN_CLR:   rd_val = s_en & s_mg;
            WIN_PD_SET:               rd_val = (s_pd | s_lvl) & s_m1;
            WIN_PD_CLR:               rd_val = (s_pd | s_lvl) & s_m2;
            WIN_AC_SET, WIN_AC_CLR:   rd_val = s_ac & s_m2;
            WIN_ACCESS:               rd_val = (secure && !sec_off) ? s_acc : '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (rd_en && addr_ok)  rd_data <= rd_val;
        else                        rd_data <= '0;
    end

    assert_unimpl_rdz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_ok) |=> (rd_data == '0));

    assert_idle_rdz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    assert_group_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win == WIN_GROUP && !secure && !sec_off) |=> (rd_data == '0));
endmodule

// File: tb/test_secure_irq_bitmaps.sv
`timescale 1ns/1ps
module test_secure_irq_bitmaps;
    localparam int NUM_IRQ = 96;
    localparam int EXT = NUM_IRQ - 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sec_off = 1'b0;
    logic [EXT-1:0] edge_cfg = '1;
    logic [EXT-1:0] irq_line = '0;
    logic [7:0]     addr = '0;
    logic           wr_en = 1'b0;
    logic [31:0]    wr_data = '0;
    logic           rd_en = 1'b0;
    logic           secure = 1'b0;
    logic [31:0]    rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    secure_irq_bitmaps #(.NUM_IRQ(NUM_IRQ)) i_secure_irq_bitmaps (
        .clk(clk), .rst_n(rst_n), .sec_off(sec_off), .edge_cfg(edge_cfg),
        .irq_line(irq_line), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .secure(secure), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'h21, 32'h0,        32'h0,        8'd14}, // R14 reset value
        '{1'b1, 1'b1, 8'h01, 32'h0000FFFF, 32'h0,        8'd8},
        '{1'b0, 1'b1, 8'h01, 32'h0,        32'h0000FFFF, 8'd8},  // R8
        '{1'b0, 1'b0, 8'h01, 32'h0,        32'h0,        8'd8},  // R8 ns hidden
        '{1'b1, 1'b0, 8'h01, 32'hFFFFFFFF, 32'h0,        8'd8},
        '{1'b0, 1'b1, 8'h01, 32'h0,        32'h0000FFFF, 8'd8},  // R8 ns write ignored
        '{1'b1, 1'b0, 8'h21, 32'hFFFFFFFF, 32'h0,        8'd5},
        '{1'b0, 1'b1, 8'h21, 32'h0,        32'h0000FFFF, 8'd5},  // R5
        '{1'b1, 1'b1, 8'h21, 32'hFF000000, 32'h0,        8'd3},
        '{1'b0, 1'b0, 8'h41, 32'h0,        32'h0000FFFF, 8'd5},  // R5
        '{1'b0, 1'b1, 8'h41, 32'h0,        32'hFF00FFFF, 8'd3},  // R3
        '{1'b1, 1'b0, 8'h41, 32'hFFFFFFFF, 32'h0,        8'd5},
        '{1'b0, 1'b1, 8'h21, 32'h0,        32'hFF000000, 8'd5},  // R5
        '{1'b1, 1'b1, 8'h41, 32'h0F000000, 32'h0,        8'd3},
        '{1'b0, 1'b1, 8'h21, 32'h0,        32'hF0000000, 8'd3},  // R3
        '{1'b1, 1'b1, 8'h20, 32'hFFFFFFFF, 32'h0,        8'd1},
        '{1'b0, 1'b1, 8'h20, 32'h0,        32'h0,        8'd1},  // R1 internal word
        '{1'b1, 1'b1, 8'h23, 32'hFFFFFFFF, 32'h0,        8'd1},
        '{1'b0, 1'b1, 8'h23, 32'h0,        32'h0,        8'd1},  // R1 beyond count
        '{1'b0, 1'b1, 8'h22, 32'h0,        32'h0,        8'd1},  // R1 neighbour intact
        '{1'b1, 1'b1, 8'hE3, 32'h00000039, 32'h0,        8'd9},
        '{1'b0, 1'b1, 8'hE3, 32'h0,        32'h00000039, 8'd9},  // R9
        '{1'b0, 1'b0, 8'hE3, 32'h0,        32'h0,        8'd9},  // R9 ns hidden
        '{1'b1, 1'b1, 8'hE1, 32'hFFFFFFFF, 32'h0,        8'd2},
        '{1'b0, 1'b1, 8'hE1, 32'h0,        32'h0,        8'd2},  // R2 internal fields
        '{1'b1, 1'b0, 8'h61, 32'hFFFFFFFF, 32'h0,        8'd6},
        '{1'b0, 1'b1, 8'h61, 32'h0,        32'h0007FFFF, 8'd6},  // R6 ge1
        '{1'b0, 1'b0, 8'h61, 32'h0,        32'h0007FFFF, 8'd6},  // R6
        '{1'b0, 1'b0, 8'h81, 32'h0,        32'h0006FFFF, 8'd6},  // R6 ge2
        '{1'b1, 1'b0, 8'h81, 32'hFFFFFFFF, 32'h0,        8'd6},
        '{1'b0, 1'b1, 8'h61, 32'h0,        32'h00010000, 8'd6},  // R6
        '{1'b1, 1'b0, 8'hA1, 32'hFFFFFFFF, 32'h0,        8'd7},
        '{1'b1, 1'b1, 8'hA1, 32'h00070000, 32'h0,        8'd7},
        '{1'b0, 1'b1, 8'hC1, 32'h0,        32'h0007FFFF, 8'd7},  // R7
        '{1'b0, 1'b0, 8'hA1, 32'h0,        32'h0006FFFF, 8'd7},  // R7
        '{1'b0, 1'b0, 8'hC1, 32'h0,        32'h0006FFFF, 8'd7},  // R7
        '{1'b1, 1'b0, 8'hC1, 32'hFFFFFFFF, 32'h0,        8'd7},
        '{1'b0, 1'b1, 8'hA1, 32'h0,        32'h00070000, 8'd7},  // R7
        '{1'b1, 1'b1, 8'h22, 32'h12345678, 32'h0,        8'd1},
        '{1'b0, 1'b1, 8'h22, 32'h0,        32'h12345678, 8'd1},  // R1 word 2
        '{1'b0, 1'b0, 8'h22, 32'h0,        32'h0,        8'd5},  // R5 word 2
        '{1'b0, 1'b1, 8'h81, 32'h0,        32'h00010000, 8'd3}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic sec, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] got);
        @(negedge clk);
        wr_en = wr; rd_en = !wr; secure = sec; addr = a; wr_data = d;
        @(negedge clk);
        got = rd_data;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 rd_data after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].sec, VECS[i].a, VECS[i].d, got);
            if (!VECS[i].wr) begin
                checks++;
                if (got !== VECS[i].exp) begin
                    errors++;
                    $display("FAIL vector %0d R%0d actual %08h expected %08h",
                             i, VECS[i].req, got, VECS[i].exp);
                end
            end
        end

        // R4: result appears one cycle after rd_en, then drops back to zero
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; secure = 1'b1; addr = 8'h22;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 data in cycle after rd_en", rd_data, 32'h12345678);
        @(negedge clk);
        chk("R4 zero after idle cycle", rd_data, 32'h0);

        // R11: edge on ID 64 (ext bit 32); ID 65 level-triggered
        edge_cfg[33] = 1'b0;
        @(negedge clk);
        irq_line[32] = 1'b1;
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R11 rising edge latched", got, 32'h00000001);
        irq_line[32] = 1'b0;
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R11 falling edge keeps latch", got, 32'h00000001);
        op(1'b1, 1'b1, 8'h82, 32'h00000001, got);
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R3 clear pending", got, 32'h0);

        // R10: level interrupt merges live level
        irq_line[33] = 1'b1;
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R10 level visible", got, 32'h00000002);
        op(1'b0, 1'b0, 8'h62, 32'h0, got);
        chk("R6 ns masked level read", got, 32'h0);
        irq_line[33] = 1'b0;
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R10 level not latched", got, 32'h0);

        // R12: rising edge and clear in same cycle
        @(negedge clk);
        irq_line[34] = 1'b1;
        wr_en = 1'b1; secure = 1'b1; addr = 8'h82; wr_data = 32'h00000004;
        @(negedge clk);
        wr_en = 1'b0;
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R12 set wins over clear", got, 32'h00000004);
        op(1'b1, 1'b1, 8'h82, 32'h00000004, got);
        op(1'b0, 1'b1, 8'h62, 32'h0, got);
        chk("R11 steady high does not relatch", got, 32'h0);
        irq_line[34] = 1'b0;

        // R13: security disabled
        sec_off = 1'b1;
        op(1'b0, 1'b0, 8'h01, 32'h0, got);
        chk("R13 ns group read", got, 32'h0000FFFF);
        op(1'b1, 1'b0, 8'h21, 32'h0F000000, got);
        op(1'b0, 1'b0, 8'h21, 32'h0, got);
        chk("R13 ns full enable", got, 32'hFF000000);
        op(1'b0, 1'b1, 8'hE3, 32'h0, got);
        chk("R9 fields hidden when security off", got, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule